// File: doc/BRIEF.md
# Center-aligned PWM up-down timebase

This block is the period timer behind a symmetric, center-aligned PWM channel. Software writes a period value N into a writable, readable period register. While the enable input is high, the timer produces a signed count centred on zero. In the falling half of each switching period the count moves down from about +N/2 to about -N/2. In the rising half it moves back up. Each full period lasts exactly 2*N clock cycles, so the switching frequency is the clock frequency divided by 2*N.

A phase flag reads 0 in the falling half and 1 in the rising half. A one-clock strobe marks the period start and another marks the midpoint. Odd and even values of N split the period in different ways. For odd N the value at each boundary is held for two clocks. For even N the count runs on without a repeat. A new period value is taken only when a period starts. Period values 0 and 1 are illegal: the timer halts, holds its count at zero and raises an error flag. The flag stays set until enable is dropped.

Top module: `pwm_updown_timebase`

## Requirements
- R1: The period register is PW bits wide (default 16, so 0xFFFF is the largest value). A write on the clock edge where `per_wr` is high appears on `per_rdata` from the following clock, and the register is 0 after reset.
- R2: After enable is sampled high with a legal period N (N >= 2), the count is floor(N/2) on the next clock. It then falls by one per clock for N clocks in total, with `phase` at 0.
- R3: The rising half follows: for N clocks `phase` is 1, the count starts at -floor(N/2) and rises by one per clock. The next period then begins, so every period lasts exactly 2*N clocks.
- R4: For odd N = 2k+1, the falling half runs +k down to -k and the rising half runs -k up to +k. The values -k and +k are therefore each held for two consecutive clocks at the boundaries.
- R5: For even N = 2k, the falling half runs +k down to -k+1 and the rising half runs -k up to k-1, with no repeated value at either boundary.
- R6: `pstart` is high for exactly the one clock in which the count shows the start value of a period. `pmid` is high for exactly the one clock in which it shows the reloaded negative value. The two are never high together.
- R7: A period value written while the timer runs does not change the current period. It takes effect at the next period start.
- R8: If the period value is 0 or 1 when a period would start, the timer halts with count 0, `phase` 0 and no strobes, and `err` goes high. `err` stays high while enable stays high, even after a legal value is written.
- R9: One clock after enable is sampled low, `err`, `phase`, `pstart` and `pmid` are 0. The count then equals floor(P/2), where P is the period register value, and it follows later writes to the register.
- R10: After reset, the count is 0, `phase`, `pstart`, `pmid` and `err` are 0, and `per_rdata` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Timer run enable |
| per_wr | input | 1 | Period register write strobe |
| per_wdata | input | PW | Period value to write |
| per_rdata | output | PW | Period register readback |
| cnt | output | PW+1 | Signed up-down count |
| phase | output | 1 | 0 in the falling half, 1 in the rising half |
| pstart | output | 1 | One-clock period-start strobe |
| pmid | output | 1 | One-clock midpoint strobe |
| err | output | 1 | Sticky illegal-period flag, cleared by dropping enable |

## Verification
The bench builds the timer with PW = 6, so legal periods run from 2 to 63. This small width lets the bench sweep every legal period over two full periods each, covering all odd and even splits against an arithmetic model of the count, phase and strobes. It also covers both illegal values, a shadowed write in the middle of a period, an illegal value picked up at a period boundary, and the disabled state following the register.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
  typedef enum logic [1:0] {
    TB_IDLE  = 2'd0,
    TB_RUN   = 2'd1,
    TB_FAULT = 2'd2
  } tb_state_e;
endpackage

// File: rtl/pwm_period_shadow.sv
module pwm_period_shadow #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (wr) rdata <= wdata;
  end

  p_rdback_r1: assert property (@(posedge clk) disable iff (rst)
    $past(wr) |-> rdata == $past(wdata));
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core
  import pwm_tb_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [PW-1:0]        shadow,
  output logic signed [PW:0]   cnt,
  output logic                 phase,
  output logic                 pstart,
  output logic                 pmid,
  output logic                 err
);
  localparam int CW = PW + 1;

  tb_state_e            state;
  logic [PW-1:0]        act;
  logic [PW-1:0]        rem;
  logic signed [CW-1:0] sh_half;
  logic signed [CW-1:0] act_half;
  logic                 sh_bad;
  logic                 at_end;

  assign sh_half  = $signed({2'b00, shadow[PW-1:1]});
  assign act_half = $signed({2'b00, act[PW-1:1]});
  assign sh_bad   = (shadow < PW'(2));
  assign at_end   = (rem == '0);
  assign err      = (state == TB_FAULT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TB_IDLE;
      act    <= '0;
      rem    <= '0;
      cnt    <= '0;
      phase  <= 1'b0;
      pstart <= 1'b0;
      pmid   <= 1'b0;
    end else if (!en) begin
      state  <= TB_IDLE;
      cnt    <= sh_half;
      phase  <= 1'b0;
      pstart <= 1'b0;
      pmid   <= 1'b0;
    end else begin
      pstart <= 1'b0;
      pmid   <= 1'b0;
      if (state == TB_FAULT) begin
        cnt   <= '0;
        phase <= 1'b0;
      end else if (state == TB_IDLE || (at_end && phase)) begin
        if (sh_bad) begin
          state <= TB_FAULT;
          cnt   <= '0;
          phase <= 1'b0;
        end else begin
          state  <= TB_RUN;
          act    <= shadow;
          cnt    <= sh_half;
          phase  <= 1'b0;
          pstart <= 1'b1;
          rem    <= shadow - PW'(1);
        end
      end else if (at_end) begin
        phase <= 1'b1;
        cnt   <= -act_half;
        pmid  <= 1'b1;
        rem   <= act - PW'(1);
      end else begin
        cnt <= phase ? cnt + CW'(1) : cnt - CW'(1);
        rem <= rem - PW'(1);
      end
    end
  end

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(pstart && pmid));
  p_mid_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(phase) |-> pmid);
  p_err_zero_r8: assert property (@(posedge clk) disable iff (rst)
    err |-> (cnt == '0 && !phase && !pstart && !pmid));
  p_range_r2: assert property (@(posedge clk) disable iff (rst)
    (state == TB_RUN) |-> (cnt <= act_half && cnt >= -act_half));
  p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && state == TB_RUN && $past(state) == TB_RUN
     && !pstart && !pmid && !phase) |-> cnt == $past(cnt) - CW'(1));
  p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && state == TB_RUN && $past(state) == TB_RUN
     && !pstart && !pmid && phase) |-> cnt == $past(cnt) + CW'(1));
  p_disable_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!en) |-> (!err && !phase && !pstart && !pmid));
endmodule

// File: rtl/pwm_updown_timebase.sv
module pwm_updown_timebase #(
  parameter int PW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               per_wr,
  input  logic [PW-1:0]      per_wdata,
  output logic [PW-1:0]      per_rdata,
  output logic signed [PW:0] cnt,
  output logic               phase,
  output logic               pstart,
  output logic               pmid,
  output logic               err
);
  pwm_period_shadow #(.PW(PW)) shadow_i (
    .clk   (clk),
    .rst   (rst),
    .wr    (per_wr),
    .wdata (per_wdata),
    .rdata (per_rdata)
  );

  pwm_count_core #(.PW(PW)) core_i (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .shadow (per_rdata),
    .cnt    (cnt),
    .phase  (phase),
    .pstart (pstart),
    .pmid   (pmid),
    .err    (err)
  );

  p_start_phase_r2: assert property (@(posedge clk) disable iff (rst)
    pstart |-> !phase);
endmodule

// File: tb/pwm_updown_timebase_tb.sv
`timescale 1ns/1ps
module pwm_updown_timebase_tb_top;
  localparam int PW = 6;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               en = 1'b0;
  logic               per_wr = 1'b0;
  logic [PW-1:0]      per_wdata = '0;
  logic [PW-1:0]      per_rdata;
  logic signed [PW:0] cnt;
  logic               phase, pstart, pmid, err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_updown_timebase #(.PW(PW)) dut_i (
    .clk(clk), .rst(rst), .en(en), .per_wr(per_wr), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .cnt(cnt), .phase(phase), .pstart(pstart),
    .pmid(pmid), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic write_per(input int v);
    @(negedge clk);
    per_wr = 1'b1;
    per_wdata = PW'(v);
    @(negedge clk);
    per_wr = 1'b0;
  endtask

  // Check one sample at offset t (0..2N-1) inside a period of length 2N.
  task automatic check_pos(input int n, input int t);
    int exp_c;
    bit exp_ph;
    exp_ph = (t >= n);
    exp_c = exp_ph ? -(n / 2) + (t - n) : (n / 2) - t;
    chk(int'(cnt) == exp_c, (n % 2) ? "R4 count" : "R5 count", int'(cnt), exp_c);
    chk(phase == exp_ph, exp_ph ? "R3 phase" : "R2 phase", int'(phase), int'(exp_ph));
    chk(pstart == (t == 0), "R6 pstart", int'(pstart), int'(t == 0));
    chk(pmid == (t == n), "R6 pmid", int'(pmid), int'(t == n));
    chk(err == 1'b0, "R2 err", int'(err), 0);
  endtask

  task automatic check_idle(input int p, input string tag);
    @(negedge clk);
    chk(int'(cnt) == p / 2, tag, int'(cnt), p / 2);
    chk(!phase && !pstart && !pmid && !err, tag,
        int'({phase, pstart, pmid, err}), 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(int'(cnt) == 0 && !phase && !pstart && !pmid && !err, "R10 outputs",
        int'(cnt), 0);
    chk(per_rdata == '0, "R10 rdata", int'(per_rdata), 0);

    // R1 readback
    write_per(42);
    chk(int'(per_rdata) == 42, "R1 rdata", int'(per_rdata), 42);
    write_per(63);
    chk(int'(per_rdata) == 63, "R1 rdata max", int'(per_rdata), 63);

    // R2..R6 sweep of all legal periods over two periods each
    for (int n = 2; n < (1 << PW); n++) begin
      write_per(n);
      check_idle(n, "R9 idle follows register");
      en = 1'b1;
      for (int t = 0; t < 4 * n; t++) begin
        @(negedge clk);
        check_pos(n, t % (2 * n));
      end
      en = 1'b0;
      check_idle(n, "R9 disable");
    end

    // R7 shadowed write mid-period
    write_per(10);
    en = 1'b1;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      check_pos(10, t);
      if (t == 3) begin per_wr = 1'b1; per_wdata = PW'(7); end
      if (t == 4) per_wr = 1'b0;
      if (t == 6) chk(int'(per_rdata) == 7, "R7 rdata", int'(per_rdata), 7);
    end
    for (int t = 0; t < 14; t++) begin
      @(negedge clk);
      check_pos(7, t);
    end

    // R8 illegal value picked up at period boundary
    per_wr = 1'b1; per_wdata = PW'(1);
    @(negedge clk);
    per_wr = 1'b0;
    for (int t = 1; t < 14; t++) @(negedge clk);
    @(negedge clk);
    chk(err == 1'b1, "R8 err at boundary", int'(err), 1);
    chk(int'(cnt) == 0, "R8 count zero", int'(cnt), 0);
    en = 1'b0;
    check_idle(1, "R8 err cleared by disable");

    // R8 illegal value at start, sticky after legal write
    write_per(0);
    en = 1'b1;
    @(negedge clk);
    chk(err == 1'b1, "R8 err at start", int'(err), 1);
    chk(int'(cnt) == 0 && !pstart && !phase, "R8 halted", int'(cnt), 0);
    write_per(12);
    repeat (3) begin
      @(negedge clk);
      chk(err == 1'b1, "R8 sticky", int'(err), 1);
      chk(int'(cnt) == 0 && !pstart, "R8 stays halted", int'(cnt), 0);
    end
    en = 1'b0;
    check_idle(12, "R9 recover");
    en = 1'b1;
    for (int t = 0; t < 24; t++) begin
      @(negedge clk);
      check_pos(12, t);
    end
    en = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule